// File: doc/BRIEF.md
# Single-Vector Dense Layer Engine

The engine computes one fully-connected neural-network layer for one input vector at a time. A parameterised array of signed 8-bit multipliers is organised as N slices of M lanes. Every slice owns an adder tree and yields one partial dot product per accepted input chunk. All weights and biases sit in on-chip storage, so a vector streamed one chunk per cycle is consumed with no stall and no wait for other vectors.

A start pulse selects an output group (N output neurons), the number of M-wide input chunks, and a requantization shift. The N accumulators are preset from the group's bias entry. Chunks then stream in under a valid/ready handshake. After the last chunk the sums pass through ReLU, an arithmetic right shift and saturation to 0..127. The engine then raises a one-cycle done pulse with the 8-bit results, which feed the next layer.

Top module: `mlp_layer_engine`

## Requirements
- R1: After reset `busy_o`, `done_o` and `in_ready_o` are 0 and `out_o` is all zeros.
- R2: A `start_i` pulse while idle captures `group_i`, `nchunks_i` (legal range 1..MAX_CHUNKS) and `shift_i`, and presets the N accumulators from the bias entry of that group. On the next cycle `busy_o` and `in_ready_o` are 1.
- R3: Output lane n (`out_o[8n+7:8n]`) equals sat(relu(bias[g][n] + sum over chunks c and lanes m of x[c][m]*w[g][c][n][m]) >>> shift). Input element m sits at `in_data_i[8m+7:8m]`. Weight (n,m) sits at bits `[(n*M+m)*8 +: 8]` of the tile at address g*MAX_CHUNKS+c. Bias n sits at `bias_data_i[32n+31:32n]`. All values are two's complement.
- R4: A lane whose accumulated value is negative outputs 0.
- R5: A lane whose shifted value exceeds 127 outputs 127.
- R6: The shift is arithmetic and right-ward by `shift_i` bits, applied after ReLU.
- R7: A chunk is taken only on a cycle with `in_valid_i` and `in_ready_o` both high. Idle gaps between chunks do not change the result.
- R8: `in_ready_o` drops once `nchunks` chunks have been taken. Further valid data is ignored and does not affect the result.
- R9: `done_o` goes high for exactly one cycle, 4 cycles after the clock edge that took the last chunk. `busy_o` falls on that same edge and only then.
- R10: A `start_i` pulse while busy is ignored. The running layer finishes with its original group, chunk count and shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a layer evaluation |
| group_i | input | GW | Output group to compute |
| nchunks_i | input | CW | Number of M-wide input chunks |
| shift_i | input | SHW | Requantization right shift |
| in_valid_i | input | 1 | Input chunk valid |
| in_data_i | input | M*8 | Input chunk, M signed bytes |
| in_ready_o | output | 1 | Engine can take a chunk |
| wt_we_i | input | 1 | Weight tile write enable |
| wt_addr_i | input | WAW | Weight tile address (group*MAX_CHUNKS+chunk) |
| wt_data_i | input | M*N*8 | Weight tile, N*M signed bytes |
| bias_we_i | input | 1 | Bias entry write enable |
| bias_addr_i | input | GW | Bias entry (group) address |
| bias_data_i | input | N*32 | N signed 32-bit biases |
| busy_o | output | 1 | Layer in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| out_o | output | N*8 | Activated 8-bit results |

## Verification
A bad product, tree sum or accumulator shows up in `out_o` at the done pulse, 4 cycles after the last chunk is taken. Sweeps across groups, chunk counts and shifts expose any lane, tile-address or bit-position mix-up as a value mismatch. Control faults show as a done pulse one cycle early or late, a stuck ready, or a result that absorbs an extra chunk or a stray start. Each of these is visible in the cycles right around the done pulse.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  typedef logic signed [7:0]  op_t;
  typedef logic signed [15:0] prod_t;
  typedef logic signed [31:0] acc_t;
  localparam int unsigned QMAX = 127;
endpackage

// File: rtl/mlp_mac_slice.sv
module mlp_mac_slice
  import mlp_pkg::*;
#(
  parameter int unsigned M = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M*8-1:0] x_i,
  input  logic [M*8-1:0] w_i,
  output acc_t           sum_o
);
  prod_t prod_q [M];
  acc_t  tree_sum;
  acc_t  sum_q;

  for (genvar m = 0; m < M; m++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[m] <= '0;
      else         prod_q[m] <= prod_t'(op_t'(x_i[m*8 +: 8])) * prod_t'(op_t'(w_i[m*8 +: 8]));
    end
  end

  always_comb begin
    tree_sum = '0;
    for (int m = 0; m < M; m++) tree_sum = tree_sum + acc_t'(prod_q[m]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= tree_sum;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/mlp_act_quant.sv
module mlp_act_quant
  import mlp_pkg::*;
#(
  parameter int unsigned SHW = 5
) (
  input  acc_t           acc_i,
  input  logic [SHW-1:0] shift_i,
  output logic [7:0]     q_o
);
  acc_t rel;
  acc_t shf;

  always_comb begin
    rel = acc_i[31] ? '0 : acc_i;
    shf = rel >>> shift_i;
    q_o = (shf > acc_t'(QMAX)) ? 8'(QMAX) : shf[7:0];
  end

  // R4
  always_comb begin
    if (acc_i[31] == 1'b1) relu_zero_chk: assert (q_o == 8'd0);
  end
endmodule

// File: rtl/mlp_layer_engine.sv
module mlp_layer_engine
  import mlp_pkg::*;
#(
  parameter int unsigned M          = 4,
  parameter int unsigned N          = 2,
  parameter int unsigned MAX_CHUNKS = 4,
  parameter int unsigned GROUPS     = 2,
  parameter int unsigned SHW        = 5,
  localparam int unsigned CW  = $clog2(MAX_CHUNKS + 1),
  localparam int unsigned GW  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned WD  = GROUPS * MAX_CHUNKS,
  localparam int unsigned WAW = (WD > 1) ? $clog2(WD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [GW-1:0]    group_i,
  input  logic [CW-1:0]    nchunks_i,
  input  logic [SHW-1:0]   shift_i,
  input  logic             in_valid_i,
  input  logic [M*8-1:0]   in_data_i,
  output logic             in_ready_o,
  input  logic             wt_we_i,
  input  logic [WAW-1:0]   wt_addr_i,
  input  logic [M*N*8-1:0] wt_data_i,
  input  logic             bias_we_i,
  input  logic [GW-1:0]    bias_addr_i,
  input  logic [N*32-1:0]  bias_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [N*8-1:0]   out_o
);
  logic [M*N*8-1:0] wmem [WD];
  logic [N*32-1:0]  bmem [GROUPS];

  logic           busy_q, done_q, fin_q;
  logic [GW-1:0]  grp_q;
  logic [CW-1:0]  nch_q, cnt_q;
  logic [SHW-1:0] shift_q;
  logic           v1, v2, v3, last1, last2, last3;
  logic [M*8-1:0]   x1;
  logic [M*N*8-1:0] w1;
  acc_t           acc_q [N];
  acc_t           psum  [N];
  logic [7:0]     q     [N];
  logic [N*8-1:0] out_q;

  logic           start_ok, take, take_last;
  logic [WAW-1:0] rd_addr;

  assign start_ok   = start_i && !busy_q;
  assign in_ready_o = busy_q && (cnt_q < nch_q);
  assign take       = in_ready_o && in_valid_i;
  assign take_last  = take && (cnt_q == nch_q - CW'(1));
  assign rd_addr    = WAW'(int'(grp_q) * MAX_CHUNKS + int'(cnt_q));

  always_ff @(posedge clk_i) begin
    if (wt_we_i)   wmem[wt_addr_i]   <= wt_data_i;
    if (bias_we_i) bmem[bias_addr_i] <= bias_data_i;
    if (take) begin
      x1 <= in_data_i;
      w1 <= wmem[rd_addr];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; fin_q <= 1'b0;
      grp_q <= '0; nch_q <= '0; cnt_q <= '0; shift_q <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      last1 <= 1'b0; last2 <= 1'b0; last3 <= 1'b0;
    end else begin
      v1 <= take;  last1 <= take_last;
      v2 <= v1;    last2 <= last1;
      v3 <= v2;    last3 <= last2;
      fin_q  <= v3 && last3;
      done_q <= fin_q;
      if (start_ok) begin
        busy_q <= 1'b1; grp_q <= group_i; nch_q <= nchunks_i;
        shift_q <= shift_i; cnt_q <= '0;
      end else begin
        if (take)  cnt_q  <= cnt_q + CW'(1);
        if (fin_q) busy_q <= 1'b0;
      end
    end
  end

  for (genvar n = 0; n < N; n++) begin : g_lane
    mlp_mac_slice #(.M(M)) u_slice (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (x1),
      .w_i   (w1[n*M*8 +: M*8]),
      .sum_o (psum[n])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       acc_q[n] <= '0;
      else if (start_ok) acc_q[n] <= acc_t'(bmem[group_i][n*32 +: 32]);
      else if (v3)       acc_q[n] <= acc_q[n] + psum[n];
    end

    mlp_act_quant #(.SHW(SHW)) u_act (
      .acc_i  (acc_q[n]),
      .shift_i(shift_q),
      .q_o    (q[n])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    out_q[n*8 +: 8] <= '0;
      else if (fin_q) out_q[n*8 +: 8] <= q[n];
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign out_o  = out_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R8
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> busy_o);
  // R2
  start_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && nchunks_i != '0) |=> (busy_o && in_ready_o));
  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ($stable(grp_q) && $stable(nch_q) && $stable(shift_q)));
endmodule

// File: tb/sim_mlp_layer_engine.sv
`timescale 1ns/1ps
module sim_mlp_layer_engine;
  localparam int M = 4, N = 2, MC = 4, G = 2, SHW = 5;
  localparam int CW = $clog2(MC + 1), GW = 1, WAW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, wt_we = 1'b0, bias_we = 1'b0;
  logic [GW-1:0] group = '0, bias_addr = '0;
  logic [CW-1:0] nchunks = '0;
  logic [SHW-1:0] shift = '0;
  logic [M*8-1:0] in_data = '0;
  logic [WAW-1:0] wt_addr = '0;
  logic [M*N*8-1:0] wt_data = '0;
  logic [N*32-1:0] bias_data = '0;
  logic in_ready, busy, done;
  logic [N*8-1:0] out;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mlp_layer_engine #(.M(M), .N(N), .MAX_CHUNKS(MC), .GROUPS(G), .SHW(SHW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .group_i(group),
    .nchunks_i(nchunks), .shift_i(shift), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .wt_we_i(wt_we),
    .wt_addr_i(wt_addr), .wt_data_i(wt_data), .bias_we_i(bias_we),
    .bias_addr_i(bias_addr), .bias_data_i(bias_data), .busy_o(busy),
    .done_o(done), .out_o(out));

  function automatic int wv(int g, int c, int n, int m);
    return ((g*53 + c*31 + n*17 + m*7 + 3) * 37) % 256 - 128;
  endfunction
  function automatic int xv(int t, int c, int m);
    if (t < 0) return 0;
    return ((t*29 + c*13 + m*19 + 5) * 41) % 256 - 128;
  endfunction
  function automatic int bv(int g, int n);
    if (g == 0) return (n == 0) ? 1000 : -500;
    return (n == 0) ? 40 : -3;
  endfunction
  function automatic int expect_lane(int g, int nch, int sh, int n, int t);
    int a = bv(g, n);
    for (int c = 0; c < nch; c++)
      for (int m = 0; m < M; m++) a += xv(t, c, m) * wv(g, c, n, m);
    if (a < 0) a = 0;
    a = a >>> sh;
    if (a > 127) a = 127;
    return a;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_layer(int g, int nch, int sh, int t, bit gaps, bit extra, bit intr, string req);
    @(negedge clk);
    start = 1'b1; group = GW'(g); nchunks = CW'(nch); shift = SHW'(sh);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    chk(in_ready == 1'b1, "R2 ready", int'(in_ready), 1);
    for (int c = 0; c < nch; c++) begin
      if (gaps && c > 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      for (int m = 0; m < M; m++) in_data[m*8 +: 8] = 8'(xv(t, c, m));
      if (intr && c == 0) begin
        start = 1'b1; group = GW'(1 - g); nchunks = CW'(1); shift = SHW'(31 - sh);
      end
      @(negedge clk);
      start = 1'b0;
    end
    // one edge past the last take
    if (extra) begin
      in_data = '1;
      chk(in_ready == 1'b0, "R8 ready low", int'(in_ready), 0);
    end else in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk(done == 1'b0, "R9 early done", int'(done), 0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R9 done", int'(done), 1);
    chk(busy == 1'b0, "R9 busy drop", int'(busy), 0);
    for (int n = 0; n < N; n++) begin
      int e = expect_lane(g, nch, sh, n, t);
      chk(int'(out[n*8 +: 8]) == e, req, int'(out[n*8 +: 8]), e);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);
    chk(out == '0, "R1 out", int'(out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < G; g++) begin
      for (int c = 0; c < MC; c++) begin
        wt_we = 1'b1; wt_addr = WAW'(g*MC + c);
        for (int n = 0; n < N; n++)
          for (int m = 0; m < M; m++) wt_data[(n*M+m)*8 +: 8] = 8'(wv(g, c, n, m));
        @(negedge clk);
      end
      wt_we = 1'b0;
      bias_we = 1'b1; bias_addr = GW'(g);
      for (int n = 0; n < N; n++) bias_data[n*32 +: 32] = 32'(bv(g, n));
      @(negedge clk);
      bias_we = 1'b0;
    end
    // zero input: bias only. R5 lane0 saturates, R4 lane1 zero
    run_layer(0, 1, 0, -1, 0, 0, 0, "R5 R4 bias");
    // R6 1000>>>3 = 125
    run_layer(0, 2, 3, -1, 0, 0, 0, "R6 shift");
    run_layer(1, 1, 0, -1, 0, 0, 0, "R4 small bias");
    run_layer(1, 3, 3, -1, 0, 0, 0, "R6 small shift");
    // R3 sweep over groups, lengths and shifts; R7 gaps, R8 extra data, R10 stray start
    for (int g = 0; g < G; g++)
      for (int nch = 1; nch <= MC; nch++)
        for (int si = 0; si < 4; si++) begin
          int t = g*16 + nch*4 + si;
          run_layer(g, nch, si*4 + 1, t, (si == 1), (si == 2), (si == 3),
                    (si == 1) ? "R7 gaps" : (si == 2) ? "R8 extra" :
                    (si == 3) ? "R10 stray start" : "R3 dot");
        end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule